// File: doc/BRIEF.md
# Register-Programmed SPI Master Engine

This block is an SPI master driven through a small word-wide register bus. Software writes the clock divisor, the clock mode, the bit order and the duplex choice into a configuration register, then places up to four command bytes in a command word and up to 32 payload bytes in eight data words. It gives the bit length of each phase in a count register and writes a start bit. The engine then runs one transaction, framed by the chip selects that software enabled. The command bits go out first, then the payload bits, then the receive bits. Software polls a busy flag to see when the transaction has finished.

Received bits are stored in a separate receive buffer. When the transaction ends, that buffer is copied into the readable view of the data words. A read of a data word therefore always returns the result of the last completed transaction, while a write to a data word loads the transmit buffer. While a transaction runs, the engine accepts no register writes. This keeps the configuration, the counts and the transmit data fixed for the whole frame.

Top module: `spi_regbus_master`

## Requirements
- R1: After reset every register reads 0. `sclk` and `mosi` are 0 and every `cs_n` line is 1.
- R2: A write of 1 to bit 8 of the control register (offset 0x00) starts a transaction. Control bit 16 reads 1 from the cycle after that write for exactly (N+1)*D cycles. N is the total number of bits shifted and D is the divisor.
- R3: Bits 27:16 of the configuration register (offset 0x28) hold D-2, so D runs from 2 to 4097, and the stored fields read back as written. Each bit lasts D system cycles. Within each bit, SCLK is high for floor(D/2) cycles; for an odd D the extra cycle goes to the low half.
- R4: Configuration bit 4 (CPOL) sets the idle level of SCLK and bit 5 (CPHA) selects the sampling edge: the first edge of a bit when CPHA is 0, the second edge when CPHA is 1. MOSI holds steady for the whole bit, and MISO is captured on the sampling edge. All four modes are supported.
- R5: Bits 29:24 of the count register (offset 0x2C) give the command bit count C (0 to 32). The command bits are shifted first. With MSB-first order they are sent from bit C-1 of the command word (offset 0x04) down to bit 0, which makes the command right-justified.
- R6: Bits 8:0 of the count register give the payload bit count T (0 to 256). Payload byte n sits in data word n/4 (offset 0x08+4*(n/4)) at bits 8*(n%4)+7 to 8*(n%4). Payload bytes are sent in increasing n, each with its most significant bit first.
- R7: Configuration bit 3 set means each byte is sent least significant bit first. This covers the command bytes, with C a multiple of 8, as well as the payload and receive bytes.
- R8: In half duplex (configuration bit 10 = 0), bits 20:12 of the count register give the receive bit count R (0 to 256), so N = C+T+R. The receive bits follow the payload with no gap. They are stored from byte 0 upwards in the payload byte and bit layout. When the transaction ends, the data words read back these bits, and any bit that was not received reads 0.
- R9: In full duplex (configuration bit 10 = 1), the receive count is ignored and N = C+T. MISO is captured during the payload bits, and each payload bit's captured value is stored in that payload bit's own position.
- R10: Bits 1:0 of the chip-select register (offset 0x38) enable the two selects. `cs_n[i]` is 0 during a transaction exactly when bit i is set, and 1 at all other times.
- R11: Any register write made while busy is ignored, including a second start request. The running transaction keeps its length, and the written register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 2 | Active-low chip selects |

## Verification
The assertions take three things for granted. The configuration and the counts stay fixed while busy, which holds because writes are blocked. An LSB-first command phase uses a whole number of bytes. The counts stay within the 32-bit command word and the 256-bit buffer. The stimulus draws random modes, divisors, duplex settings and phase lengths only within those limits, and it uses an LSB-first command count only in steps of 8. It drives MISO the way a slave would, changing it only on the shifting edge of SCLK, so a captured bit never depends on a race at the sampling edge.

// File: rtl/spim_pkg.sv
// Package: register offsets, field positions and shared types of the SPI master.
// Assumes a byte-addressed register bus with word-aligned 32-bit registers.
package spim_pkg;

    localparam int unsigned OFF_CTRL   = 'h00;
    localparam int unsigned OFF_OPCODE = 'h04;
    localparam int unsigned OFF_DATA0  = 'h08;
    localparam int unsigned OFF_MASTER = 'h28;
    localparam int unsigned OFF_COUNT  = 'h2C;
    localparam int unsigned OFF_CSPOL  = 'h38;

    localparam int unsigned START_BIT  = 8;
    localparam int unsigned BUSY_BIT   = 16;
    localparam int unsigned LSB_BIT    = 3;
    localparam int unsigned CPOL_BIT   = 4;
    localparam int unsigned CPHA_BIT   = 5;
    localparam int unsigned DUPLEX_BIT = 10;
    localparam int unsigned DIV_LSB    = 16;
    localparam int unsigned DIV_W      = 12;

    localparam int unsigned CMDB_LSB   = 24;
    localparam int unsigned CMDB_W     = 6;
    localparam int unsigned RXB_LSB    = 12;
    localparam int unsigned RXB_W      = 9;
    localparam int unsigned TXB_LSB    = 0;
    localparam int unsigned TXB_W      = 9;

    // Line settings taken from the configuration register.
    typedef struct packed {
        logic [DIV_W-1:0] div_m2;
        logic             full;
        logic             cpha;
        logic             cpol;
        logic             lsb;
    } line_cfg_t;

    // Phase lengths taken from the count register.
    typedef struct packed {
        logic [CMDB_W-1:0] cmd;
        logic [RXB_W-1:0]  rx;
        logic [TXB_W-1:0]  tx;
    } phase_len_t;

endpackage

// File: rtl/spim_regs.sv
// Register file of the SPI master: configuration, counts, command word,
// transmit buffer and chip-select enables, plus the read mux.
// Assumes word-aligned accesses; every write is dropped while busy is high.
module spim_regs
    import spim_pkg::*;
#(
    parameter int unsigned NCS        = 2,
    parameter int unsigned DATA_WORDS = 8,
    parameter int unsigned ADDR_W     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic                     busy,
    input  logic [DATA_WORDS*32-1:0] rx_view,
    output line_cfg_t                cfg_q,
    output phase_len_t               len_q,
    output logic [31:0]              cmd_q,
    output logic [DATA_WORDS*32-1:0] tx_q,
    output logic [NCS-1:0]           cs_en_q,
    output logic                     start
);

    localparam int unsigned DATA_END = OFF_DATA0 + 4 * DATA_WORDS;

    logic              wr_ok;
    logic              in_data;
    logic [ADDR_W-1:0] data_off;

    assign wr_ok = bus_we && !busy;
    assign start = wr_ok && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[START_BIT];

    // Configuration register: divisor, duplex, clock mode, bit order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_ok && bus_addr == ADDR_W'(OFF_MASTER)) begin
            cfg_q.div_m2 <= bus_wdata[DIV_LSB +: DIV_W];
            cfg_q.full   <= bus_wdata[DUPLEX_BIT];
            cfg_q.cpha   <= bus_wdata[CPHA_BIT];
            cfg_q.cpol   <= bus_wdata[CPOL_BIT];
            cfg_q.lsb    <= bus_wdata[LSB_BIT];
        end
    end

    // Count register: bit lengths of the three phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (wr_ok && bus_addr == ADDR_W'(OFF_COUNT)) begin
            len_q.cmd <= bus_wdata[CMDB_LSB +: CMDB_W];
            len_q.rx  <= bus_wdata[RXB_LSB +: RXB_W];
            len_q.tx  <= bus_wdata[TXB_LSB +: TXB_W];
        end
    end

    // Command word and chip-select enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            cs_en_q <= '0;
        end else if (wr_ok) begin
            if (bus_addr == ADDR_W'(OFF_OPCODE)) cmd_q   <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_CSPOL))  cs_en_q <= bus_wdata[NCS-1:0];
        end
    end

    // One transmit word per data offset.
    for (genvar w = 0; w < DATA_WORDS; w++) begin : g_txw
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tx_q[w*32 +: 32] <= '0;
            end else if (wr_ok && bus_addr == ADDR_W'(OFF_DATA0 + 4 * w)) begin
                tx_q[w*32 +: 32] <= bus_wdata;
            end
        end
    end

    assign data_off = bus_addr - ADDR_W'(OFF_DATA0);
    assign in_data  = (bus_addr >= ADDR_W'(OFF_DATA0)) && (int'(bus_addr) < int'(DATA_END))
                      && (bus_addr[1:0] == 2'b00);

    // Read mux: busy flag, stored fields, last completed receive data.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL)) begin
            bus_rdata[BUSY_BIT] = busy;
        end else if (bus_addr == ADDR_W'(OFF_OPCODE)) begin
            bus_rdata = cmd_q;
        end else if (bus_addr == ADDR_W'(OFF_MASTER)) begin
            bus_rdata[DIV_LSB +: DIV_W] = cfg_q.div_m2;
            bus_rdata[DUPLEX_BIT]       = cfg_q.full;
            bus_rdata[CPHA_BIT]         = cfg_q.cpha;
            bus_rdata[CPOL_BIT]         = cfg_q.cpol;
            bus_rdata[LSB_BIT]          = cfg_q.lsb;
        end else if (bus_addr == ADDR_W'(OFF_COUNT)) begin
            bus_rdata[CMDB_LSB +: CMDB_W] = len_q.cmd;
            bus_rdata[RXB_LSB +: RXB_W]   = len_q.rx;
            bus_rdata[TXB_LSB +: TXB_W]   = len_q.tx;
        end else if (bus_addr == ADDR_W'(OFF_CSPOL)) begin
            bus_rdata[NCS-1:0] = cs_en_q;
        end else if (in_data) begin
            bus_rdata = rx_view[int'(data_off[ADDR_W-1:2]) * 32 +: 32];
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cfg_q) && $stable(len_q) && $stable(tx_q))); // R11

endmodule

// File: rtl/spim_cellclk.sv
// Bit-cell timer: counts D = div_m2 + 2 system cycles per bit and flags the
// cell end and the mid-cell edge. A first half at low level gets ceil(D/2).
// Assumes div_m2 is stable while en is high.
module spim_cellclk #(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_m2,
    input  logic             lead_lvl,
    output logic             cell_end,
    output logic             mid_pulse,
    output logic             in_first
);

    localparam int unsigned CW = DIV_W + 1;

    logic [CW-1:0] dv;
    logic [CW-1:0] h1;
    logic [CW-1:0] cnt;

    assign dv        = CW'(div_m2) + CW'(2);
    assign h1        = lead_lvl ? (dv >> 1) : ((dv + CW'(1)) >> 1);
    assign cell_end  = en && (cnt == dv - CW'(1));
    assign mid_pulse = en && (cnt == h1);
    assign in_first  = cnt < h1;

    // Cycle counter within a bit cell, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || cell_end) cnt <= '0;
        else                           cnt <= cnt + CW'(1);
    end

    AST_CELL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < dv)); // R3

endmodule

// File: rtl/spim_engine.sv
// Transaction engine: walks command, payload and receive bits, drives SCLK
// and MOSI, captures MISO at mid-cell and publishes the receive buffer at the
// end. Assumes the configuration and counts do not change while busy.
module spim_engine
    import spim_pkg::*;
#(
    parameter int unsigned BUF_BITS = 256,
    parameter int unsigned CMD_MAX  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  line_cfg_t           cfg,
    input  phase_len_t          len,
    input  logic [31:0]         cmd,
    input  logic [BUF_BITS-1:0] tx_bits,
    input  logic                miso,
    output logic                busy,
    output logic                sclk,
    output logic                mosi,
    output logic [BUF_BITS-1:0] rx_view
);

    localparam int unsigned IDX_W = $clog2(BUF_BITS);
    localparam int unsigned K_W   = IDX_W + 3;

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} eng_state_t;

    eng_state_t          st;
    logic [K_W-1:0]      k;
    logic [K_W-1:0]      cmd_e, tx_e, rx_e, total;
    logic [K_W-1:0]      q_tx, q_rx, ci;
    logic                in_cmd, in_tx, in_rx;
    logic                lead;
    logic                cell_end, mid_pulse, in_first;
    logic                cap_en;
    logic [IDX_W-1:0]    cap_idx;
    logic [BUF_BITS-1:0] rx_work;

    function automatic logic [IDX_W-1:0] bit_pos(input logic [K_W-1:0] q, input logic lsb);
        bit_pos = {q[IDX_W-1:3], lsb ? q[2:0] : ~q[2:0]};
    endfunction

    // Phase lengths clamped to the storage behind them.
    always_comb begin
        cmd_e = (K_W'(len.cmd) > K_W'(CMD_MAX))  ? K_W'(CMD_MAX)  : K_W'(len.cmd);
        tx_e  = (K_W'(len.tx)  > K_W'(BUF_BITS)) ? K_W'(BUF_BITS) : K_W'(len.tx);
        rx_e  = (K_W'(len.rx)  > K_W'(BUF_BITS)) ? K_W'(BUF_BITS) : K_W'(len.rx);
        total = cmd_e + tx_e + (cfg.full ? '0 : rx_e);
    end

    // Phase decode of the current bit.
    always_comb begin
        in_cmd = k < cmd_e;
        q_tx   = k - cmd_e;
        in_tx  = !in_cmd && (q_tx < tx_e);
        q_rx   = q_tx - tx_e;
        in_rx  = !in_cmd && !in_tx;
        ci     = cfg.lsb ? (cmd_e - K_W'(8) - {k[K_W-1:3], 3'b000} + K_W'(k[2:0]))
                         : (cmd_e - K_W'(1) - k);
    end

    assign lead = cfg.cpol ^ cfg.cpha;
    assign busy = (st != ST_IDLE);

    spim_cellclk #(.DIV_W(DIV_W)) u_cellclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (busy),
        .div_m2    (cfg.div_m2),
        .lead_lvl  (lead),
        .cell_end  (cell_end),
        .mid_pulse (mid_pulse),
        .in_first  (in_first)
    );

    // Sequencer: idle, shifting bit cells, one trailing cell before release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            k  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st <= (total == '0) ? ST_TAIL : ST_SHIFT;
                    k  <= '0;
                end
                ST_SHIFT: if (cell_end) begin
                    if (k == total - K_W'(1)) st <= ST_TAIL;
                    else                      k  <= k + K_W'(1);
                end
                ST_TAIL: if (cell_end) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Serial outputs: data held for a whole cell, clock idles at CPOL.
    always_comb begin
        mosi = 1'b0;
        if (st == ST_SHIFT) begin
            if (in_cmd)     mosi = cmd[ci[4:0]];
            else if (in_tx) mosi = tx_bits[bit_pos(q_tx, cfg.lsb)];
        end
        sclk = (st == ST_SHIFT) ? (in_first ? lead : !lead) : cfg.cpol;
    end

    assign cap_en  = (st == ST_SHIFT) && mid_pulse && (cfg.full ? in_tx : in_rx);
    assign cap_idx = cfg.full ? bit_pos(q_tx, cfg.lsb) : bit_pos(q_rx, cfg.lsb);

    // Receive capture into the work buffer, published when the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_work <= '0;
            rx_view <= '0;
        end else begin
            if (st == ST_IDLE && start) rx_work <= '0;
            else if (cap_en)            rx_work[cap_idx] <= miso;
            if (st == ST_TAIL && cell_end) rx_view <= rx_work;
        end
    end

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && $past(st == ST_SHIFT) && !$past(cell_end)) |-> $stable(mosi)); // R4

    AST_VIEW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rx_view)); // R8

    AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT) |-> (k < total)); // R2

endmodule

// File: rtl/spi_regbus_master.sv
// Top of the register-programmed SPI master: register file, transaction
// engine and one active-low select per enable bit, low while busy.
// Assumes a single-master register bus with one-cycle writes.
module spi_regbus_master
    import spim_pkg::*;
#(
    parameter int unsigned NCS        = 2,
    parameter int unsigned DATA_WORDS = 8,
    parameter int unsigned ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_n
);

    localparam int unsigned BUF_BITS = DATA_WORDS * 32;

    line_cfg_t           cfg_q;
    phase_len_t          len_q;
    logic [31:0]         cmd_q;
    logic [BUF_BITS-1:0] tx_q;
    logic [BUF_BITS-1:0] rx_view;
    logic [NCS-1:0]      cs_en_q;
    logic                start;
    logic                busy;

    spim_regs #(.NCS(NCS), .DATA_WORDS(DATA_WORDS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rx_view   (rx_view),
        .cfg_q     (cfg_q),
        .len_q     (len_q),
        .cmd_q     (cmd_q),
        .tx_q      (tx_q),
        .cs_en_q   (cs_en_q),
        .start     (start)
    );

    spim_engine #(.BUF_BITS(BUF_BITS)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cfg     (cfg_q),
        .len     (len_q),
        .cmd     (cmd_q),
        .tx_bits (tx_q),
        .miso    (miso),
        .busy    (busy),
        .sclk    (sclk),
        .mosi    (mosi),
        .rx_view (rx_view)
    );

    // Chip selects framed by the busy window.
    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = !(busy && cs_en_q[i]);
    end

endmodule

// File: tb/spi_regbus_master_bench.sv
`timescale 1ns/1ps
module spi_regbus_master_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [1:0]  cs_n;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  pat [0:1023];
    bit  got [0:1023];
    logic [31:0] txw [0:7];

    always #2.5 clk = ~clk;

    spi_regbus_master u_spi_regbus_master (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Expected MOSI bit k, derived from R5, R6, R7.
    function automatic bit exp_mosi(input int k, input int op, input int tx,
                                    input logic [31:0] opc, input bit lsb);
        logic [7:0] bv;
        int q, b, j;
        if (k < op) begin
            if (!lsb) return opc[op-1-k];
            b = k / 8; j = k % 8;
            bv = 8'(opc >> (op - 8 - 8*b));
            return bv[j];
        end
        if (k < op + tx) begin
            q = k - op; b = q / 8; j = q % 8;
            bv = 8'(txw[b/4] >> (8*(b%4)));
            return lsb ? bv[j] : bv[7-j];
        end
        return 1'b0;
    endfunction

    task automatic xfer(input bit cpol, input bit cpha, input bit lsb, input bit full,
                        input int dv, input int op, input int tx, input int rx,
                        input logic [1:0] csen, input bit inject);
        logic [31:0] mval, v, opc;
        logic [255:0] exp_rx;
        int n, nrx, busy_cyc, hi, ns, last_edge, sidx, bad_bits, kk, b, j;
        bit per_bad, prev, lead, bsy;
        logic [1:0] csmask;

        mval = (32'(dv - 2) << 16) | (32'(full) << 10) | (32'(cpha) << 5)
             | (32'(cpol) << 4) | (32'(lsb) << 3);
        wr(6'h28, mval);
        wr(6'h2C, (32'(op) << 24) | (32'(rx) << 12) | 32'(tx));
        opc = $urandom;
        wr(6'h04, opc);
        for (int w = 0; w < 8; w++) begin
            txw[w] = $urandom;
            wr(6'(8 + 4*w), txw[w]);
        end
        wr(6'h38, {30'd0, csen});
        rd(6'h28, v);
        chk(v == mval, "R3", "config readback", v, mval);
        for (int i = 0; i < 1024; i++) pat[i] = 1'($urandom);

        n = op + tx + (full ? 0 : rx);
        lead = cpol ^ cpha;
        sidx = cpha ? -1 : 0;
        miso = cpha ? 1'b0 : pat[0];
        busy_cyc = 0; hi = 0; ns = 0; last_edge = -1; per_bad = 0;
        prev = cpol; csmask = '0;

        @(negedge clk);
        bus_we = 1'b1; bus_addr = 6'h00; bus_wdata = 32'h100;
        while (1) begin
            @(negedge clk);
            bus_we = 1'b0; bus_addr = 6'h00;
            if (inject && busy_cyc == 2) begin bus_we = 1'b1; bus_wdata = 32'h100; end
            if (inject && busy_cyc == 3) begin bus_we = 1'b1; bus_addr = 6'h04; bus_wdata = ~opc; end
            #1;
            bsy = (bus_addr == 6'h00) ? bus_rdata[16] : 1'b1;
            if (!bsy) break;
            busy_cyc++;
            if (busy_cyc > 40000) break;
            if (sclk) hi++;
            csmask = csmask | ~cs_n;
            if (sclk != prev) begin
                if (sclk != lead) begin
                    got[ns] = mosi;
                    if (last_edge >= 0 && busy_cyc - last_edge != dv) per_bad = 1;
                    last_edge = busy_cyc;
                    ns++;
                end else begin
                    sidx++;
                    if (sidx >= 0) miso = pat[sidx];
                end
            end
            prev = sclk;
        end
        bus_we = 1'b0;

        chk(busy_cyc == (n + 1) * dv, "R2", "busy cycles", busy_cyc, (n + 1) * dv);
        chk(ns == n, "R4", "sampling edges", ns, n);
        bad_bits = 0;
        for (int k = 0; k < n && k < ns; k++)
            if (got[k] != (k < op + tx ? exp_mosi(k, op, tx, opc, lsb) : 1'b0)) bad_bits++;
        chk(bad_bits == 0, (lsb ? "R7" : "R5/R6"), "mosi bit mismatches", bad_bits, 0);
        chk(!per_bad, "R3", "sclk period", 32'(per_bad), 0);
        chk(hi == n * (dv / 2) + (cpol ? dv : 0), "R3", "sclk high cycles", hi,
            n * (dv / 2) + (cpol ? dv : 0));
        chk(csmask == csen, "R10", "selects asserted", csmask, csen);
        chk(cs_n == 2'b11 && sclk == cpol, "R10", "idle select/clock", {cs_n, sclk}, {2'b11, cpol});

        exp_rx = '0;
        nrx = full ? tx : rx;
        for (int q = 0; q < nrx; q++) begin
            kk = full ? op + q : op + tx + q;
            b = q / 8; j = q % 8;
            exp_rx[b*8 + (lsb ? j : 7 - j)] = pat[kk];
        end
        for (int w = 0; w < 8; w++) begin
            rd(6'(8 + 4*w), v);
            chk(v == exp_rx[w*32 +: 32], (full ? "R9" : "R8"), "receive word", v, exp_rx[w*32 +: 32]);
        end
        if (inject) begin
            rd(6'h04, v);
            chk(v == opc, "R11", "command word after busy write", v, opc);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd51966));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b0 && mosi == 1'b0 && cs_n == 2'b11, "R1", "reset pins", {cs_n, sclk, mosi}, 4'b1100);
        foreach (v[i]) ; // no-op keeps v declared use simple
        rd(6'h00, v); chk(v == 0, "R1", "control", v, 0);
        rd(6'h04, v); chk(v == 0, "R1", "command", v, 0);
        rd(6'h08, v); chk(v == 0, "R1", "data0", v, 0);
        rd(6'h28, v); chk(v == 0, "R1", "config", v, 0);
        rd(6'h2C, v); chk(v == 0, "R1", "count", v, 0);
        rd(6'h38, v); chk(v == 0, "R1", "selects", v, 0);

        // Directed corner cases.
        xfer(0, 0, 0, 0, 2, 8, 16, 8, 2'b01, 0);     // R4 mode 0, smallest divisor
        xfer(1, 1, 0, 0, 7, 32, 8, 8, 2'b10, 0);     // R3 odd divisor, mode 3
        xfer(0, 1, 1, 0, 4, 16, 24, 16, 2'b11, 0);   // R7 LSB first, mode 1
        xfer(1, 0, 0, 0, 3, 0, 0, 0, 2'b01, 0);      // R2 empty frame
        xfer(0, 0, 0, 1, 5, 8, 40, 64, 2'b01, 0);    // R9 full duplex ignores rx count
        xfer(0, 0, 0, 0, 3, 12, 20, 40, 2'b01, 1);   // R11 writes while busy
        xfer(1, 0, 0, 0, 2, 32, 256, 0, 2'b10, 0);   // R6 full buffer
        xfer(0, 1, 0, 0, 2, 0, 0, 256, 2'b01, 0);    // R8 full receive
        xfer(0, 0, 0, 0, 2, 0, 0, 8, 2'b00, 0);      // R8 short receive clears rest, R10 none
        xfer(1, 1, 0, 0, 4097, 8, 0, 0, 2'b01, 0);   // R3 largest divisor

        // Random mix.
        for (int t = 0; t < 24; t++) begin
            bit lsb;
            lsb = 1'($urandom);
            xfer(1'($urandom), 1'($urandom), lsb, 1'($urandom), 2 + int'($urandom % 8),
                 lsb ? 8 * int'($urandom % 5) : int'($urandom % 33),
                 int'($urandom % 65), int'($urandom % 65), 2'($urandom), 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule